// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a short shift register of the most recent resolved branch outcomes, shared by all branches. The low-order bits of the branch address pick an entry in a counter table. Each entry holds one 2-bit saturating counter for every possible value of the shared history. The current history value picks which counter in the entry gives the guess. The counter's upper bit is the guess.

The fetch stage presents an address on the lookup port, and the guess appears on a registered output one clock later. When the branch is resolved, the execute stage presents the same address, the actual outcome and a valid strobe. The counter selected by the address and the current history moves one step toward the outcome, and the outcome is then shifted into the history. No tag is stored, so branches whose index bits match share counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken), the history is 00, and every lookup predicts not taken.
- R2: `lk_pred` is registered. It shows the upper bit of the selected counter one clock after `lk_pc` is sampled, so counter values 2 and 3 give 1 (taken).
- R3: A counter at 3 stays at 3 when trained with taken.
- R4: A counter at 0 stays at 0 when trained with not taken.
- R5: A counter trained from 3 needs two not-taken resolves to predict not taken, and a counter trained from 0 needs two taken resolves to predict taken.
- R6: The counter index is {PC[ENTRY_BITS+ALIGN_W-1:ALIGN_W], history}. The history is 2 bits, so each entry holds four counters.
- R7: A valid resolve changes only the counter indexed by its PC and the pre-update history. The other counters, including those in the same entry, stay unchanged.
- R8: On a valid resolve the history becomes {old bit 0, outcome}. Bit 1 is the older outcome and bit 0 the newest (1 = taken). The history does not change without `rs_valid`.
- R9: PC bits below ALIGN_W and above the index field are ignored, so aliasing addresses share counters.
- R10: A lookup in the same cycle as a resolve uses the history and counter values from before that resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Address of the branch to predict |
| lk_pred | output | 1 | Registered guess, 1 = taken |
| rs_valid | input | 1 | Resolve strobe |
| rs_pc | input | PC_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The bench drives counters into both saturation limits and then applies single and double reversals. A counter that wraps at its limits, or that has no hysteresis, shows the wrong guess. It trains one history slot and reads the other slots of the same entry, which catches an index that ignores the history or writes more than one counter. It also catches a history that shifts in the wrong direction. Lookups aimed at aliased and misaligned addresses, and a lookup in the same cycle as a resolve, catch an index built from the wrong PC bits and a read that returns post-update values.

// File: rtl/corr_bp_pkg.sv
package corr_bp_pkg;
  typedef logic [1:0] ctr2_t;
  localparam ctr2_t CTR_INIT = 2'd1;

  function automatic ctr2_t ctr_train(input ctr2_t c, input logic taken);
    ctr2_t n;
    if (taken) n = (c == 2'd3) ? c : c + 2'd1;
    else       n = (c == 2'd0) ? c : c - 2'd1;
    return n;
  endfunction
endpackage

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
  p_shift_r8: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (hist[0] == $past(bit_in)) && (hist[1] == $past(hist[0])));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import corr_bp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_taken,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  // Read port: registered, returns value before any same-edge write.
  always_ff @(posedge clk) begin
    if (rst) rd_taken <= 1'b0;
    else     rd_taken <= mem[rd_idx][1];
  end

  // Write port: one counter per cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_train(mem[wr_idx], wr_taken);
    end
  end

  p_sat_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && mem[wr_idx] == 2'd3) |=> mem[$past(wr_idx)] == 2'd3);
  p_sat_lo_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && mem[wr_idx] == 2'd0) |=> mem[$past(wr_idx)] == 2'd0);
  p_read_old_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rd_taken == $past(mem[rd_idx][1]));
  p_untouched_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_idx != wr_idx) |=> mem[$past(rd_idx)] == $past(mem[rd_idx]));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int PC_W       = 32,
  parameter int ALIGN_W    = 2,
  parameter int ENTRY_BITS = 8,
  parameter int HIST_W     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_pred,
  input  logic            rs_valid,
  input  logic [PC_W-1:0] rs_pc,
  input  logic            rs_taken
);
  localparam int IDX_W = ENTRY_BITS + HIST_W;

  logic [HIST_W-1:0] ghist;
  logic [IDX_W-1:0]  lk_idx, rs_idx;

  assign lk_idx = {lk_pc[ALIGN_W+ENTRY_BITS-1:ALIGN_W], ghist};
  assign rs_idx = {rs_pc[ALIGN_W+ENTRY_BITS-1:ALIGN_W], ghist};

  bp_ghist #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(rs_valid), .bit_in(rs_taken), .hist(ghist)
  );

  bp_ctr_table #(.IDX_W(IDX_W)) u_tab (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_taken(lk_pred),
    .wr_en(rs_valid), .wr_idx(rs_idx), .wr_taken(rs_taken)
  );

  p_reset_pred_r1: assert property (@(posedge clk) rst |=> !lk_pred);
endmodule

// File: tb/sim_corr_bpred.sv
module sim_corr_bpred;
  logic clk = 0, rst = 1;
  logic [31:0] lk_pc = 0, rs_pc = 0;
  logic rs_valid = 0, rs_taken = 0;
  logic lk_pred;
  int n_chk = 0, n_bad = 0;
  int mctr [1024];
  logic [1:0] mh;

  always #2.5 clk = ~clk;

  corr_bpred u0 (.clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_pred(lk_pred),
                 .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

  function automatic int ix(input logic [31:0] pc, input logic [1:0] h);
    return int'(((pc >> 2) & 32'hFF) * 4 + h);
  endfunction

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (lk_pred !== exp) begin
      n_bad++;
      $display("FAIL %s: lk_pred=%0b expected=%0b", tag, lk_pred, exp);
    end
  endtask

  // One cycle: drive, model, clock, compare against model
  task automatic step(input logic rv, input logic [31:0] rpc, input logic rt,
                      input logic [31:0] lpc, input string tag);
    logic exp;
    @(negedge clk);
    rs_valid = rv; rs_pc = rpc; rs_taken = rt; lk_pc = lpc;
    exp = mctr[ix(lpc, mh)] >= 2;
    if (rv) begin
      int k = ix(rpc, mh);
      if (rt && mctr[k] < 3) mctr[k]++;
      else if (!rt && mctr[k] > 0) mctr[k]--;
      mh = {mh[0], rt};
    end
    @(posedge clk); #1;
    rs_valid = 0;
    @(negedge clk);
    check(exp, tag);
  endtask

  localparam logic [65:0] VEC [12] = '{
    {1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b1, 32'h0000_0100},
    {1'b1, 32'h0000_0204, 1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0204, 1'b1, 32'h0000_0204},
    {1'b0, 32'h0000_0000, 1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b1, 32'h0000_0204},
    {1'b1, 32'h0000_0204, 1'b0, 32'h0000_0100},
    {1'b1, 32'h0000_0100, 1'b0, 32'h0000_0100},
    {1'b0, 32'h0000_0000, 1'b0, 32'h0000_0204}
  };

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) mctr[i] = 1;
    mh = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    check(1'b0, "R1 reset");
    step(0, 0, 0, 32'h0000_0FFC, "R1 untouched entry");

    // Table walk: mixed training and lookups, R2 R6 R8 R10
    for (int v = 0; v < 12; v++)
      step(VEC[v][65], VEC[v][64:33], VEC[v][32], VEC[v][31:0], "R2 table walk");

    // Reset again for hand-tracked directed tests
    @(negedge clk); rst = 1; @(posedge clk); #1 rst = 0;
    for (int i = 0; i < 1024; i++) mctr[i] = 1;
    mh = 2'b00;
    @(negedge clk);
    check(1'b0, "R1 after second reset");

    // History 00 -> 01 -> 11 via pc 0x300; then A=0x100 at history 11
    step(1, 32'h300, 1, 32'h100, "R10 pre-update lookup");
    step(1, 32'h300, 1, 32'h100, "R6 history 01 slot");
    step(1, 32'h100, 1, 32'h100, "R10 same-cycle read old");   // A11 1->2, hist 11
    step(0, 0, 0, 32'h100, "R2 counter 2 predicts taken");
    step(1, 32'h100, 1, 32'h100, "R2 counter 2");              // ->3
    step(1, 32'h100, 1, 32'h100, "R3 at 3");                   // stays 3
    step(1, 32'h100, 1, 32'h100, "R3 saturate high");
    step(1, 32'h100, 0, 32'h100, "R3 still taken");            // 3->2, hist 10
    step(1, 32'h500, 1, 32'h104, "R7 neighbour entry");        // hist 01
    step(1, 32'h500, 1, 32'h100, "R5 one miss keeps taken");   // hist 11
    step(1, 32'h100, 0, 32'h101, "R9 alignment bits ignored"); // 2->1, hist 10
    step(1, 32'h500, 1, 32'h500, "R8 no change");              // hist 01
    step(1, 32'h500, 1, 32'hF00, "R7 other slot");             // hist 11
    step(0, 0, 0, 32'h100, "R5 two misses flip");
    step(0, 0, 0, 32'h0010_0100, "R9 alias high PC bits");
    // Other slots of entry A untouched: history 00 via not-taken on 0x600
    step(1, 32'h600, 0, 32'h100, "R7 slot 11");
    step(1, 32'h600, 0, 32'h100, "R8 history 10");
    step(1, 32'h100, 0, 32'h100, "R7 slot 00 untouched");      // A00 1->0
    step(1, 32'h100, 0, 32'h100, "R4 at 0");                   // stays 0
    step(1, 32'h100, 1, 32'h100, "R4 saturate low");           // 0->1, hist 01
    step(1, 32'h600, 0, 32'h100, "R6 slot 01");                // hist 10
    step(1, 32'h600, 0, 32'h100, "R8 slot 10");                // hist 00
    step(1, 32'h100, 1, 32'h100, "R5 one taken from low");     // 1->2, hist 01
    step(1, 32'h600, 0, 32'h100, "R8 older bit");              // hist 10
    step(1, 32'h600, 0, 32'h100, "R6 slot 10");                // hist 00
    step(0, 0, 0, 32'h100, "R5 two taken flip");
    // No valid: history must stay 00
    step(0, 32'h100, 1, 32'h100, "R8 invalid resolve ignored");
    step(0, 32'h100, 1, 32'h100, "R8 history held");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule